// File: doc/BRIEF.md
# Remote-Write Register Scoreboard

This block is the register file of one processing cluster for a single thread: fourteen data registers, each paired with a full/empty flag that tells whether its value may be consumed. Two producers write into it: results of local operations, and values that other clusters push over the inter-cluster switch. A consumer asks through an issue port whether the source registers of its next operation hold valid values. The operation either issues or stalls.

Local writes mark their destination empty when the operation issues and full when the result comes back. A remote producer never touches the flag when it sends. The consumer must clear the target ahead of time with an explicit empty command. The arriving remote value fills the register and so releases any reader stalled on it. Remote values pass through one extra register stage, so they land one cycle later than local results.

The issue port is a valid/ready pair. `iss_ready` is a combinational function of the current flags and the selected sources. An operation is taken only on a cycle with both `iss_valid` and `iss_ready` high. A stalled operation may hold `iss_valid` and its fields until the flags allow it through. Writeback, remote and empty inputs are plain single-cycle strobes with no back-pressure.

Top module: `remote_write_scoreboard`

## Requirements
- R1: After reset every flag is full and every register reads zero.
- R2: An issued operation (valid and ready) with `iss_dst_use` high makes its destination empty from the next cycle.
- R3: A local writeback stores `wb_data` and makes the register full from the next cycle.
- R4: `iss_ready` is low while any used source is empty. A stalled operation clears no destination.
- R5: A source whose use bit is low does not affect `iss_ready`.
- R6: An empty command makes the named register empty from the next cycle.
- R7: A remote write is held for one cycle in a stage register. Its data and full flag become visible two clock edges after it is presented, which is one edge later than a local writeback.
- R8: When a fill (local or staged remote) and a clear (issue destination or empty command) hit the same register in the same cycle, the register ends full with the written data.
- R9: When a local writeback and a staged remote write hit the same register in the same cycle, the remote data is kept.
- R10: Indices 14 and 15 are ignored by writes, clears and empties. As a source, such an index reads full with zero data.
- R11: Source data and `iss_ready` reflect the register contents before this cycle's clock edge. Same-cycle writes are not forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Operation offered for issue |
| iss_ready | output | 1 | All used sources full |
| iss_src0_use | input | 1 | Source 0 is read |
| iss_src0_idx | input | 4 | Source 0 register index |
| iss_src1_use | input | 1 | Source 1 is read |
| iss_src1_idx | input | 4 | Source 1 register index |
| iss_dst_use | input | 1 | Operation has a local destination |
| iss_dst_idx | input | 4 | Destination index |
| iss_src0_data | output | 64 | Source 0 value |
| iss_src1_data | output | 64 | Source 1 value |
| wb_valid | input | 1 | Local result strobe |
| wb_idx | input | 4 | Local result index |
| wb_data | input | 64 | Local result value |
| rmt_valid | input | 1 | Remote write strobe |
| rmt_idx | input | 4 | Remote write index |
| rmt_data | input | 64 | Remote write value |
| clr_valid | input | 1 | Empty command strobe |
| clr_idx | input | 4 | Register to empty |

## Verification
Source data and `iss_ready` are due in the same cycle as the request. Local fills, issue clears and empty commands show one edge later, and remote writes show two edges later. The bench drives every vector just after a falling edge and samples shortly after, before the next rising edge. A check therefore sees exactly the edges counted for that action. The remote-latency vectors check the register once while the value is still staged and again after it lands.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int SB_REGS   = 14;
  localparam int SB_DATA_W = 64;
  localparam int SB_IDX_W  = $clog2(SB_REGS);

  typedef enum logic [1:0] {
    FILL_NONE   = 2'd0,
    FILL_LOCAL  = 2'd1,
    FILL_REMOTE = 2'd2
  } fill_src_e;
endpackage

// File: rtl/sb_remote_stage.sv
module sb_remote_stage #(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [IDX_W-1:0]  in_idx,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_vld,
  output logic [IDX_W-1:0]  out_idx,
  output logic [DATA_W-1:0] out_data
);
  // switch traversal: one register between the switch and the file
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_idx  <= '0;
      out_data <= '0;
    end else begin
      out_vld  <= in_vld;
      out_idx  <= in_idx;
      out_data <= in_data;
    end
  end
endmodule

// File: rtl/sb_flag_bank.sv
module sb_flag_bank #(
  parameter int NUM_REGS = 14,
  parameter int IDX_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fill_a_vld,
  input  logic [IDX_W-1:0]    fill_a_idx,
  input  logic                fill_b_vld,
  input  logic [IDX_W-1:0]    fill_b_idx,
  input  logic                drain_a_vld,
  input  logic [IDX_W-1:0]    drain_a_idx,
  input  logic                drain_b_vld,
  input  logic [IDX_W-1:0]    drain_b_idx,
  output logic [NUM_REGS-1:0] full
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flag
    logic hit_fill, hit_drain;
    assign hit_fill  = (fill_a_vld  && fill_a_idx  == IDX_W'(g)) ||
                       (fill_b_vld  && fill_b_idx  == IDX_W'(g));
    assign hit_drain = (drain_a_vld && drain_a_idx == IDX_W'(g)) ||
                       (drain_b_vld && drain_b_idx == IDX_W'(g));
    // a fill always wins over a drain in the same cycle
    always_ff @(posedge clk) begin
      if (!rst_n)         full[g] <= 1'b1;
      else if (hit_fill)  full[g] <= 1'b1;
      else if (hit_drain) full[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/sb_data_bank.sv
module sb_data_bank
  import sb_pkg::*;
#(
  parameter int NUM_REGS = 14,
  parameter int IDX_W    = 4,
  parameter int DATA_W   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loc_vld,
  input  logic [IDX_W-1:0]  loc_idx,
  input  logic [DATA_W-1:0] loc_data,
  input  logic              rem_vld,
  input  logic [IDX_W-1:0]  rem_idx,
  input  logic [DATA_W-1:0] rem_data,
  input  logic [IDX_W-1:0]  rd0_idx,
  input  logic [IDX_W-1:0]  rd1_idx,
  output logic [DATA_W-1:0] rd0_data,
  output logic [DATA_W-1:0] rd1_data
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    fill_src_e sel;
    always_comb begin
      if (rem_vld && rem_idx == IDX_W'(g))      sel = FILL_REMOTE;
      else if (loc_vld && loc_idx == IDX_W'(g)) sel = FILL_LOCAL;
      else                                      sel = FILL_NONE;
    end
    always_ff @(posedge clk) begin
      if (!rst_n) regs_q[g] <= '0;
      else begin
        case (sel)
          FILL_REMOTE: regs_q[g] <= rem_data;
          FILL_LOCAL:  regs_q[g] <= loc_data;
          default:     regs_q[g] <= regs_q[g];
        endcase
      end
    end
  end

  always_comb begin
    rd0_data = '0;
    rd1_data = '0;
    if (int'(rd0_idx) < NUM_REGS) rd0_data = regs_q[rd0_idx];
    if (int'(rd1_idx) < NUM_REGS) rd1_data = regs_q[rd1_idx];
  end
endmodule

// File: rtl/remote_write_scoreboard.sv
module remote_write_scoreboard
  import sb_pkg::*;
#(
  parameter int NUM_REGS = SB_REGS,
  parameter int DATA_W   = SB_DATA_W,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  output logic              iss_ready,
  input  logic              iss_src0_use,
  input  logic [IDX_W-1:0]  iss_src0_idx,
  input  logic              iss_src1_use,
  input  logic [IDX_W-1:0]  iss_src1_idx,
  input  logic              iss_dst_use,
  input  logic [IDX_W-1:0]  iss_dst_idx,
  output logic [DATA_W-1:0] iss_src0_data,
  output logic [DATA_W-1:0] iss_src1_data,
  input  logic              wb_valid,
  input  logic [IDX_W-1:0]  wb_idx,
  input  logic [DATA_W-1:0] wb_data,
  input  logic              rmt_valid,
  input  logic [IDX_W-1:0]  rmt_idx,
  input  logic [DATA_W-1:0] rmt_data,
  input  logic              clr_valid,
  input  logic [IDX_W-1:0]  clr_idx
);
  logic              stg_vld;
  logic [IDX_W-1:0]  stg_idx;
  logic [DATA_W-1:0] stg_data;
  logic [NUM_REGS-1:0] full_q;
  logic              src0_ok, src1_ok, issue_fire;

  sb_remote_stage #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_vld(rmt_valid), .in_idx(rmt_idx), .in_data(rmt_data),
    .out_vld(stg_vld), .out_idx(stg_idx), .out_data(stg_data)
  );

  sb_flag_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .fill_a_vld(wb_valid),  .fill_a_idx(wb_idx),
    .fill_b_vld(stg_vld),   .fill_b_idx(stg_idx),
    .drain_a_vld(issue_fire && iss_dst_use), .drain_a_idx(iss_dst_idx),
    .drain_b_vld(clr_valid), .drain_b_idx(clr_idx),
    .full(full_q)
  );

  sb_data_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rst_n(rst_n),
    .loc_vld(wb_valid), .loc_idx(wb_idx), .loc_data(wb_data),
    .rem_vld(stg_vld),  .rem_idx(stg_idx), .rem_data(stg_data),
    .rd0_idx(iss_src0_idx), .rd1_idx(iss_src1_idx),
    .rd0_data(iss_src0_data), .rd1_data(iss_src1_data)
  );

  // out-of-range source indices count as full
  always_comb begin
    src0_ok = 1'b1;
    src1_ok = 1'b1;
    if (iss_src0_use && int'(iss_src0_idx) < NUM_REGS) src0_ok = full_q[iss_src0_idx];
    if (iss_src1_use && int'(iss_src1_idx) < NUM_REGS) src1_ok = full_q[iss_src1_idx];
  end

  assign iss_ready  = src0_ok && src1_ok;
  assign issue_fire = iss_valid && iss_ready;
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int NUM_REGS = 14,
  parameter int IDX_W    = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                iss_valid,
  input logic                iss_ready,
  input logic                iss_src0_use,
  input logic [IDX_W-1:0]    iss_src0_idx,
  input logic                iss_dst_use,
  input logic [IDX_W-1:0]    iss_dst_idx,
  input logic                wb_valid,
  input logic [IDX_W-1:0]    wb_idx,
  input logic                rmt_valid,
  input logic [IDX_W-1:0]    rmt_idx,
  input logic                clr_valid,
  input logic [IDX_W-1:0]    clr_idx,
  input logic                stg_vld,
  input logic [IDX_W-1:0]    stg_idx,
  input logic [NUM_REGS-1:0] full_q
);
  logic past_ok;
  always_ff @(posedge clk) past_ok <= rst_n;

  assert_wb_fill_R3: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    (wb_valid && int'(wb_idx) < NUM_REGS) |=> full_q[$past(wb_idx)]);

  assert_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_src0_use && int'(iss_src0_idx) < NUM_REGS && !full_q[iss_src0_idx]) |-> !iss_ready);

  assert_remote_fill_R7: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    (rmt_valid && int'(rmt_idx) < NUM_REGS) |=> ##1 full_q[$past(rmt_idx, 2)]);

  assert_empty_R6: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    (clr_valid && int'(clr_idx) < NUM_REGS && !(wb_valid && wb_idx == clr_idx)
     && !(stg_vld && stg_idx == clr_idx)) |=> !full_q[$past(clr_idx)]);

  assert_issue_clear_R2: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    (iss_valid && iss_ready && iss_dst_use && int'(iss_dst_idx) < NUM_REGS
     && !(wb_valid && wb_idx == iss_dst_idx) && !(stg_vld && stg_idx == iss_dst_idx))
    |=> !full_q[$past(iss_dst_idx)]);
endmodule

bind remote_write_scoreboard sb_checker #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_sb_checker (
  .clk(clk), .rst_n(rst_n),
  .iss_valid(iss_valid), .iss_ready(iss_ready),
  .iss_src0_use(iss_src0_use), .iss_src0_idx(iss_src0_idx),
  .iss_dst_use(iss_dst_use), .iss_dst_idx(iss_dst_idx),
  .wb_valid(wb_valid), .wb_idx(wb_idx),
  .rmt_valid(rmt_valid), .rmt_idx(rmt_idx),
  .clr_valid(clr_valid), .clr_idx(clr_idx),
  .stg_vld(stg_vld), .stg_idx(stg_idx), .full_q(full_q)
);

// File: tb/remote_write_scoreboard_bench.sv
module remote_write_scoreboard_bench;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic iss_valid, iss_ready, iss_src0_use, iss_src1_use, iss_dst_use;
  logic [3:0] iss_src0_idx, iss_src1_idx, iss_dst_idx, wb_idx, rmt_idx, clr_idx;
  logic [DW-1:0] iss_src0_data, iss_src1_data, wb_data, rmt_data;
  logic wb_valid, rmt_valid, clr_valid;

  remote_write_scoreboard u_remote_write_scoreboard (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_src0_use(iss_src0_use), .iss_src0_idx(iss_src0_idx),
    .iss_src1_use(iss_src1_use), .iss_src1_idx(iss_src1_idx),
    .iss_dst_use(iss_dst_use), .iss_dst_idx(iss_dst_idx),
    .iss_src0_data(iss_src0_data), .iss_src1_data(iss_src1_data),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data),
    .rmt_valid(rmt_valid), .rmt_idx(rmt_idx), .rmt_data(rmt_data),
    .clr_valid(clr_valid), .clr_idx(clr_idx)
  );

  typedef struct packed {
    logic wbv; logic [3:0] wbi; logic [15:0] wbd;
    logic rv;  logic [3:0] ri;  logic [15:0] rd;
    logic ev;  logic [3:0] ei;
    logic iv;  logic [3:0] s0;  logic [3:0] s1; logic u1;
    logic [3:0] dst; logic du;
    logic er;  logic [15:0] ed;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    // R11: writeback to r3 not yet visible
    '{1'b1,4'd3,16'hA1, 1'b0,4'd0,16'h0, 1'b0,4'd0, 1'b0,4'd3,4'd3,1'b0,4'd0,1'b0, 1'b1,16'h0, 8'd11},
    // R3: r3 filled; empty r5
    '{1'b0,4'd0,16'h0, 1'b0,4'd0,16'h0, 1'b1,4'd5, 1'b0,4'd3,4'd3,1'b0,4'd0,1'b0, 1'b1,16'hA1, 8'd3},
    // R6: r5 empty; remote write to r5
    '{1'b0,4'd0,16'h0, 1'b1,4'd5,16'hB2, 1'b0,4'd0, 1'b0,4'd5,4'd5,1'b0,4'd0,1'b0, 1'b0,16'h0, 8'd6},
    // R7: still staged
    '{1'b0,4'd0,16'h0, 1'b0,4'd0,16'h0, 1'b0,4'd0, 1'b0,4'd5,4'd5,1'b0,4'd0,1'b0, 1'b0,16'h0, 8'd7},
    // R7: landed
    '{1'b0,4'd0,16'h0, 1'b0,4'd0,16'h0, 1'b0,4'd0, 1'b0,4'd5,4'd5,1'b0,4'd0,1'b0, 1'b1,16'hB2, 8'd7},
    // R2: issue with dst r7
    '{1'b0,4'd0,16'h0, 1'b0,4'd0,16'h0, 1'b0,4'd0, 1'b1,4'd3,4'd3,1'b0,4'd7,1'b1, 1'b1,16'hA1, 8'd2},
    // R2: r7 empty; writeback r7
    '{1'b1,4'd7,16'hC3, 1'b0,4'd0,16'h0, 1'b0,4'd0, 1'b0,4'd7,4'd7,1'b0,4'd0,1'b0, 1'b0,16'h0, 8'd2},
    // R3: r7 full; empty r9
    '{1'b0,4'd0,16'h0, 1'b0,4'd0,16'h0, 1'b1,4'd9, 1'b0,4'd7,4'd7,1'b0,4'd0,1'b0, 1'b1,16'hC3, 8'd3},
    // R4: src1 r9 empty stalls, dst r2 must stay full
    '{1'b0,4'd0,16'h0, 1'b0,4'd0,16'h0, 1'b0,4'd0, 1'b1,4'd7,4'd9,1'b1,4'd2,1'b1, 1'b0,16'hC3, 8'd4},
    // R4: r2 not cleared; remote to r9
    '{1'b0,4'd0,16'h0, 1'b1,4'd9,16'hD4, 1'b0,4'd0, 1'b0,4'd2,4'd2,1'b0,4'd0,1'b0, 1'b1,16'h0, 8'd4},
    // R8: empty r9 same cycle as staged remote lands
    '{1'b0,4'd0,16'h0, 1'b0,4'd0,16'h0, 1'b1,4'd9, 1'b0,4'd9,4'd9,1'b0,4'd0,1'b0, 1'b0,16'h0, 8'd8},
    // R8: r9 full
    '{1'b0,4'd0,16'h0, 1'b0,4'd0,16'h0, 1'b0,4'd0, 1'b0,4'd9,4'd9,1'b0,4'd0,1'b0, 1'b1,16'hD4, 8'd8},
    // R9 setup: remote to r4
    '{1'b0,4'd0,16'h0, 1'b1,4'd4,16'hE5, 1'b0,4'd0, 1'b0,4'd4,4'd4,1'b0,4'd0,1'b0, 1'b1,16'h0, 8'd9},
    // R9: local r4 collides with staged remote
    '{1'b1,4'd4,16'hF6, 1'b0,4'd0,16'h0, 1'b0,4'd0, 1'b0,4'd4,4'd4,1'b0,4'd0,1'b0, 1'b1,16'h0, 8'd9},
    // R9: remote kept; R10 out-of-range writes
    '{1'b1,4'd14,16'h77, 1'b0,4'd0,16'h0, 1'b1,4'd15, 1'b0,4'd4,4'd4,1'b0,4'd0,1'b0, 1'b1,16'hE5, 8'd9},
    // R8: issue dst r6 with writeback to r6
    '{1'b1,4'd6,16'h66, 1'b0,4'd0,16'h0, 1'b0,4'd0, 1'b1,4'd4,4'd4,1'b0,4'd6,1'b1, 1'b1,16'hE5, 8'd8},
    // R8: r6 full; empty r1
    '{1'b0,4'd0,16'h0, 1'b0,4'd0,16'h0, 1'b1,4'd1, 1'b0,4'd6,4'd6,1'b0,4'd0,1'b0, 1'b1,16'h66, 8'd8},
    // R5: src1 r1 empty but unused
    '{1'b0,4'd0,16'h0, 1'b0,4'd0,16'h0, 1'b0,4'd0, 1'b0,4'd3,4'd1,1'b0,4'd0,1'b0, 1'b1,16'hA1, 8'd5},
    // R5: now used
    '{1'b0,4'd0,16'h0, 1'b0,4'd0,16'h0, 1'b0,4'd0, 1'b0,4'd3,4'd1,1'b1,4'd0,1'b0, 1'b0,16'hA1, 8'd5},
    // R10: index 14 as source
    '{1'b0,4'd0,16'h0, 1'b0,4'd0,16'h0, 1'b0,4'd0, 1'b0,4'd14,4'd14,1'b0,4'd0,1'b0, 1'b1,16'h0, 8'd10}
  };

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    iss_valid = 0; iss_src0_use = 1; iss_src1_use = 0; iss_dst_use = 0;
    iss_src0_idx = 0; iss_src1_idx = 0; iss_dst_idx = 0;
    wb_valid = 0; wb_idx = 0; wb_data = '0;
    rmt_valid = 0; rmt_idx = 0; rmt_data = '0;
    clr_valid = 0; clr_idx = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(20000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset state, all registers
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      iss_src0_idx = 4'(i);
      #1;
      chk($sformatf("R1 ready r%0d", i), {63'd0, iss_ready}, 64'd1);
      chk($sformatf("R1 data r%0d", i), iss_src0_data, 64'd0);
    end
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      idle();
      wb_valid = VEC[v].wbv; wb_idx = VEC[v].wbi; wb_data = {48'd0, VEC[v].wbd};
      rmt_valid = VEC[v].rv; rmt_idx = VEC[v].ri; rmt_data = {48'd0, VEC[v].rd};
      clr_valid = VEC[v].ev; clr_idx = VEC[v].ei;
      iss_valid = VEC[v].iv; iss_src0_idx = VEC[v].s0; iss_src1_idx = VEC[v].s1;
      iss_src1_use = VEC[v].u1; iss_dst_idx = VEC[v].dst; iss_dst_use = VEC[v].du;
      #1;
      chk($sformatf("R%0d vec%0d ready", VEC[v].req, v), {63'd0, iss_ready}, {63'd0, VEC[v].er});
      chk($sformatf("R%0d vec%0d data", VEC[v].req, v), iss_src0_data, {48'd0, VEC[v].ed});
    end
    // R10: index 14 write left no trace on a real register (r13 still zero)
    @(negedge clk);
    idle();
    iss_src0_idx = 4'd13;
    #1;
    chk("R10 r13 untouched", iss_src0_data, 64'd0);
    // R1: reset mid-run restores full and zero
    @(negedge clk);
    idle();
    clr_valid = 1; clr_idx = 4'd3;
    @(negedge clk);
    idle();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    iss_src0_idx = 4'd3;
    #1;
    chk("R1 reset refill ready", {63'd0, iss_ready}, 64'd1);
    chk("R1 reset clears data", iss_src0_data, 64'd0);
    finish_run();
  end
endmodule